// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sets which clocks a small 8-bit microcontroller receives. It decodes writes to a power control register. From those writes it picks normal run, idle (CPU clock stopped, peripherals clocked) or power down (oscillator disabled, every clock stopped). A separate slow bit cuts the rate of every clock enable to one pulse in 32. The slow bit can be combined with idle.

Idle and power down each need two register writes in a row: an arming write, then a confirming write. This keeps a stray store from stopping the part. Idle ends on an enabled interrupt request. Power down ends on a low level at either of two active-low wake pins. Each wake pin passes through a two-flop synchronizer first. An asynchronous reset returns the block to full-rate run from any state. While the CPU is stopped, register writes are not decoded.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the active-low reset is low, and from the moment it falls, cpuClkEn, periClkEn and oscEn are all 1. After reset is released the slow bit is clear, so all three stay 1 every cycle.
- R2: A write with bit 0 = 1 and bit 5 = 0 arms idle. If the next write has bit 5 = 1, the block enters idle. From the cycle after that write, cpuClkEn = 0, periClkEn = 1 and oscEn = 1. The confirming write does not need bit 0.
- R3: A write with bit 1 = 1 and bit 6 = 0 arms power down. If the next write has bit 6 = 1, the block enters power down. From the cycle after that write, all three enables are 0.
- R4: When a mode is armed, any write other than its confirming write clears the arm, and that write cannot arm again. A write that carries both an arm bit and its confirm bit while unarmed does nothing. Leaving a mode leaves nothing armed.
- R5: In idle, irqReq sampled high on a clock edge returns the block to run right after that edge. In run, irqReq has no effect.
- R6: In power down, irqReq is ignored. Holding either wake pin (wakePinN bit 0 or bit 1) low restores run, with all three enables back to 1 right after the third rising edge following the pin's fall.
- R7: Bit 4 = 1 in a write turns on slow mode. The enables then pulse high for one cycle in every 32. The first pulse comes in the 32nd cycle after the write, with the 31 cycles before it low.
- R8: Slow mode continues through idle. In that case periClkEn pulses once per 32 cycles and cpuClkEn stays 0. Slow mode also stays on after an interrupt wakes the block from idle.
- R9: A write with bit 4 = 0 ends slow mode. All enables in force are then 1 continuously from the cycle after that write.
- R10: If idle and power down are both armed and a single write confirms both, the block enters power down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Power control register write strobe |
| regWrData | input | 8 | Data of the register write |
| irqReq | input | 1 | Enabled peripheral interrupt request |
| wakePinN | input | 2 | Active-low external wake pins |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator run enable |

## Verification
A wrong mode state shows up on the three enables in the very next cycle. The one exception is idle under slow mode, where the gap between peripheral pulses is normal; there a stuck or wrongly armed state shows within 32 cycles as a wrong count of pulses. Arming faults cannot be seen until the following write. For that reason the vectors always follow an arming write with a confirm, a non-confirming write, or a confirm for the other mode. A synchronizer with the wrong depth moves the wake from power down by one cycle away from the third edge, and the bench samples exactly at that edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  // bit positions inside the power control register (software relies on them)
  localparam int IDLE_ARM_BIT  = 0;
  localparam int DOWN_ARM_BIT  = 1;
  localparam int SLOW_BIT      = 4;
  localparam int IDLE_CONF_BIT = 5;
  localparam int DOWN_CONF_BIT = 6;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } mode_e;

  // strobes from control to clock datapath
  typedef struct packed {
    logic slowOn;   // divide every enable by the divider ratio
    logic cpuGate;  // stop the CPU enable
    logic allGate;  // stop oscillator and every enable
  } clk_strobe_t;
endpackage

// File: rtl/pwr_ctrl_fsm.sv
module pwr_ctrl_fsm
  import pwr_mode_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             irqReq,
  input  logic             pinWake,
  output clk_strobe_t      stb,
  output mode_e            mode
);
  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << IDLE_ARM_BIT) | (1 << DOWN_ARM_BIT) | (1 << SLOW_BIT) |
           (1 << IDLE_CONF_BIT) | (1 << DOWN_CONF_BIT));

  logic idleArm, downArm, slowOn;
  logic confIdle, confDown;
  logic idleArmNext, downArmNext;
  logic unusedBits;

  assign unusedBits = ^(regWrData & ~USED_MASK);

  assign confIdle = regWrEn && idleArm && regWrData[IDLE_CONF_BIT];
  assign confDown = regWrEn && downArm && regWrData[DOWN_CONF_BIT];

  // an armed bit survives exactly one write; only an unarmed write can set it
  assign idleArmNext = !idleArm && regWrData[IDLE_ARM_BIT] && !regWrData[IDLE_CONF_BIT];
  assign downArmNext = !downArm && regWrData[DOWN_ARM_BIT] && !regWrData[DOWN_CONF_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_RUN;
      idleArm <= 1'b0;
      downArm <= 1'b0;
      slowOn  <= 1'b0;
    end else begin
      case (mode)
        MODE_RUN: begin
          if (regWrEn) begin
            slowOn  <= regWrData[SLOW_BIT];
            idleArm <= idleArmNext;
            downArm <= downArmNext;
            if (confDown)      mode <= MODE_DOWN;
            else if (confIdle) mode <= MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irqReq) begin
            mode    <= MODE_RUN;
            idleArm <= 1'b0;
            downArm <= 1'b0;
          end
        end
        MODE_DOWN: begin
          if (pinWake) begin
            mode    <= MODE_RUN;
            idleArm <= 1'b0;
            downArm <= 1'b0;
          end
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  always_comb begin
    stb.slowOn  = slowOn;
    stb.cpuGate = (mode != MODE_RUN);
    stb.allGate = (mode == MODE_DOWN);
  end
endmodule

// File: rtl/pwr_clk_dp.sv
module pwr_clk_dp
  import pwr_mode_pkg::*;
#(
  parameter int DIV_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_WAKE    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_WAKE-1:0] wakePinN,
  input  clk_strobe_t         stb,
  output logic                pinWake,
  output logic                cpuClkEn,
  output logic                periClkEn,
  output logic                oscEn
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_WAKE-1:0] pinLow;
  logic [DIV_BITS-1:0] divCnt;
  logic                divTick;
  logic                rateEn;

  // one synchronizer chain per wake pin, idling high
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], wakePinN[g]};
    end
    assign pinLow[g] = ~chain[LAST_STAGE];
  end

  assign pinWake = |pinLow;

  // slow-rate divider, held at zero while slow mode is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           divCnt <= '0;
    else if (!stb.slowOn) divCnt <= '0;
    else                 divCnt <= divCnt + 1'b1;
  end

  assign divTick = stb.slowOn && (&divCnt);
  assign rateEn  = stb.slowOn ? divTick : 1'b1;

  assign oscEn     = ~stb.allGate;
  assign periClkEn = ~stb.allGate & rateEn;
  assign cpuClkEn  = ~stb.cpuGate & rateEn;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int DIV_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_WAKE    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                irqReq,
  input  logic [NUM_WAKE-1:0] wakePinN,
  output logic                cpuClkEn,
  output logic                periClkEn,
  output logic                oscEn
);
  clk_strobe_t stb;
  mode_e       mode;
  logic        pinWake;

  pwr_ctrl_fsm #(.REG_W(REG_W)) u_fsm (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqReq(irqReq), .pinWake(pinWake), .stb(stb), .mode(mode)
  );

  pwr_clk_dp #(.DIV_BITS(DIV_BITS), .SYNC_STAGES(SYNC_STAGES), .NUM_WAKE(NUM_WAKE)) u_dp (
    .clk(clk), .rstN(rstN), .wakePinN(wakePinN), .stb(stb), .pinWake(pinWake),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  regWrEn,
  input logic  irqReq,
  input mode_e mode,
  input logic  slowOn,
  input logic  cpuClkEn,
  input logic  periClkEn,
  input logic  oscEn
);
  // R3: power down stops every enable
  p_down_stops_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DOWN) |-> (!oscEn && !cpuClkEn && !periClkEn));

  // R2: idle at full rate keeps peripherals and oscillator running
  p_idle_peri_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && !slowOn) |-> (!cpuClkEn && periClkEn && oscEn));

  // R5: an interrupt in idle returns to run at once
  p_irq_wakes_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && irqReq) |=> (mode == MODE_RUN));

  // R4: without a write, run never leaves run
  p_no_write_stays_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && !regWrEn) |=> (mode == MODE_RUN));

  // R7: slow pulses last a single cycle
  p_slow_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slowOn && periClkEn) |=> (!periClkEn || !slowOn));

  // R9: full rate run keeps the CPU enable high
  p_full_rate_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!slowOn && mode == MODE_RUN) |-> (cpuClkEn && periClkEn && oscEn));
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .irqReq(irqReq), .mode(mode),
  .slowOn(stb.slowOn), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       irqReq = 1'b0;
  logic [1:0] wakePinN = 2'b11;
  logic       cpuClkEn, periClkEn, oscEn;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqReq(irqReq), .wakePinN(wakePinN),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
  );

  // vector: {req[18:15], wr[14], data[13:6], irq[5], wakeN[4:3], exp{cpu,peri,osc}[2:0]}
  localparam int NV = 32;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'h01, 1'b0, 2'b11, 3'b111},  // R2 arm idle
    {4'd2, 1'b1, 8'h21, 1'b0, 2'b11, 3'b011},  // R2 confirm idle
    {4'd2, 1'b0, 8'h00, 1'b0, 2'b11, 3'b011},  // R2 stays idle
    {4'd5, 1'b0, 8'h00, 1'b1, 2'b11, 3'b111},  // R5 irq wakes
    {4'd5, 1'b0, 8'h00, 1'b1, 2'b11, 3'b111},  // R5 irq in run: no effect
    {4'd3, 1'b1, 8'h02, 1'b0, 2'b11, 3'b111},  // R3 arm down
    {4'd3, 1'b1, 8'h42, 1'b0, 2'b11, 3'b000},  // R3 confirm down
    {4'd6, 1'b0, 8'h00, 1'b1, 2'b11, 3'b000},  // R6 irq ignored in down
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b10, 3'b000},  // R6 pin0 low, edge 1
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b10, 3'b000},  // R6 edge 2
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b10, 3'b111},  // R6 edge 3 wakes
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b11, 3'b111},  // R6 released
    {4'd4, 1'b1, 8'h40, 1'b0, 2'b11, 3'b111},  // R4 nothing armed after wake
    {4'd4, 1'b1, 8'h01, 1'b0, 2'b11, 3'b111},  // R4 arm idle
    {4'd4, 1'b1, 8'h00, 1'b0, 2'b11, 3'b111},  // R4 other write clears arm
    {4'd4, 1'b1, 8'h20, 1'b0, 2'b11, 3'b111},  // R4 late confirm ignored
    {4'd4, 1'b1, 8'h01, 1'b0, 2'b11, 3'b111},  // R4 arm idle
    {4'd4, 1'b1, 8'h01, 1'b0, 2'b11, 3'b111},  // R4 repeated arm clears
    {4'd4, 1'b1, 8'h21, 1'b0, 2'b11, 3'b111},  // R4 arm+confirm unarmed
    {4'd4, 1'b1, 8'h21, 1'b0, 2'b11, 3'b111},  // R4 still nothing
    {4'd4, 1'b1, 8'h02, 1'b0, 2'b11, 3'b111},  // R4 arm down
    {4'd4, 1'b1, 8'h20, 1'b0, 2'b11, 3'b111},  // R4 wrong confirm clears
    {4'd4, 1'b1, 8'h40, 1'b0, 2'b11, 3'b111},  // R4 late confirm ignored
    {4'd10, 1'b1, 8'h03, 1'b0, 2'b11, 3'b111}, // R10 arm both
    {4'd10, 1'b1, 8'h63, 1'b0, 2'b11, 3'b000}, // R10 down wins
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b01, 3'b000},  // R6 pin1 low, edge 1
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b01, 3'b000},  // R6 edge 2
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b01, 3'b111},  // R6 edge 3 wakes
    {4'd6, 1'b0, 8'h00, 1'b0, 2'b11, 3'b111},  // R6 released
    {4'd2, 1'b1, 8'h01, 1'b0, 2'b11, 3'b111},  // R2 arm idle
    {4'd2, 1'b1, 8'h20, 1'b0, 2'b11, 3'b011},  // R2 confirm without bit 0
    {4'd5, 1'b0, 8'h00, 1'b1, 2'b11, 3'b111}   // R5 wake
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int req, input logic [2:0] act, input logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: enables got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkInt(input int req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL R%0d: count got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    step();
    regWrEn = 1'b0;
    regWrData = 8'h00;
  endtask

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int highCpu, highPeri, lowOsc, firstHigh;
    // R1 outputs during reset
    #3;
    chk(1, {cpuClkEn, periClkEn, oscEn}, 3'b111);
    step(); step();
    rstN = 1'b1;
    step();
    chk(1, {cpuClkEn, periClkEn, oscEn}, 3'b111);

    for (int i = 0; i < NV; i++) begin
      regWrEn   = VEC[i][14];
      regWrData = VEC[i][13:6];
      irqReq    = VEC[i][5];
      wakePinN  = VEC[i][4:3];
      step();
      chk(int'(VEC[i][18:15]), {cpuClkEn, periClkEn, oscEn}, VEC[i][2:0]);
    end
    regWrEn = 1'b0; irqReq = 1'b0; wakePinN = 2'b11;
    step();

    // R1 asynchronous reset out of idle
    wr(8'h01); wr(8'h21);
    chk(2, {cpuClkEn, periClkEn, oscEn}, 3'b011);
    #1 rstN = 1'b0;
    #1 chk(1, {cpuClkEn, periClkEn, oscEn}, 3'b111);
    step(); rstN = 1'b1; step();
    chk(1, {cpuClkEn, periClkEn, oscEn}, 3'b111);

    // R7 slow mode pulse spacing
    wr(8'h10);
    highCpu = 0; highPeri = 0; firstHigh = -1;
    for (int i = 0; i < 64; i++) begin
      if (cpuClkEn) begin
        highCpu++;
        if (firstHigh < 0) firstHigh = i;
      end
      if (periClkEn) highPeri++;
      step();
    end
    chkInt(7, highCpu, 2);
    chkInt(7, highPeri, 2);
    chkInt(7, firstHigh, 31);

    // R1 reset clears the slow bit
    #1 rstN = 1'b0;
    #1 chk(1, {cpuClkEn, periClkEn, oscEn}, 3'b111);
    step(); rstN = 1'b1; step();
    highCpu = 0;
    for (int i = 0; i < 8; i++) begin
      if (cpuClkEn) highCpu++;
      step();
    end
    chkInt(1, highCpu, 8);

    // R8 slow mode combined with idle
    wr(8'h10); wr(8'h11); wr(8'h31);
    highCpu = 0; highPeri = 0; lowOsc = 0;
    for (int i = 0; i < 64; i++) begin
      if (cpuClkEn) highCpu++;
      if (periClkEn) highPeri++;
      if (!oscEn) lowOsc++;
      step();
    end
    chkInt(8, highCpu, 0);
    chkInt(8, highPeri, 2);
    chkInt(8, lowOsc, 0);
    irqReq = 1'b1; step(); irqReq = 1'b0;
    highCpu = 0;
    for (int i = 0; i < 64; i++) begin
      if (cpuClkEn) highCpu++;
      step();
    end
    chkInt(8, highCpu, 2);

    // R9 clearing the slow bit restores full rate
    wr(8'h00);
    chk(9, {cpuClkEn, periClkEn, oscEn}, 3'b111);
    highCpu = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (cpuClkEn && periClkEn) highCpu++;
    end
    chkInt(9, highCpu, 8);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule